// File: doc/BRIEF.md
# SMBus Descriptor Sequencer

This block sits between a command descriptor and a byte-level bus engine. A descriptor names a 7-bit target, a write length (or, with the command flag set, a single command byte), a read length, a direction bit for quick commands and a block flag. From these fields alone the sequencer works out which SMBus form to run: quick command, send byte, receive byte, byte or word write, byte or word read, or block read. It then issues that form to the bit engine one operation at a time.

Each operation is a start, a repeated start, a byte write, a byte read with a chosen acknowledge, or a stop. The sequencer raises `op_req` with an operation code and holds it until the engine pulses `op_done`. On that pulse the engine also returns the read byte, the target's NAK and four error flags. Bytes to send come from an external data buffer through a read port. Received bytes go back into the buffer through a write port. When the transaction ends, the block pulses `done`, reports an outcome vector, and holds the counts of data bytes sent and received until the next transaction starts.

Controller states and their transitions:
- IDLE goes to START on `start`.
- START goes to ADDR.
- ADDR goes to one of three states:
  - WRITE when there is a write phase;
  - RCOUNT or READ when there is only a read phase;
  - STOP when there is neither.
- WRITE repeats until the last write byte. It then goes to RSTART if a read phase follows, and to STOP otherwise.
- RSTART goes to RADDR.
- RADDR goes to RCOUNT in block mode and to READ otherwise.
- RCOUNT goes to READ when the count is valid and to DRAIN when it is not.
- READ repeats until the last byte, then goes to STOP.
- DRAIN goes to STOP.
- STOP goes to FINISH.
- FINISH goes to IDLE.
- Any NAK or engine error in an operation other than STOP sends the controller to STOP.

Top module: `smbus_desc_seq`

## Requirements
- R1: The first address byte is `{target, rw}`, with rw in bit 0. rw is 0 when a write phase exists, 1 when only a read phase exists, and `d_rnw` when neither exists. The address byte after a repeated start is always `{target, 1}`.
- R2: With `d_cmd`=1, `d_wlen` itself is sent as the single write byte. With `d_cmd`=0, buffer bytes at indices 0 to `d_wlen`-1 are sent in index order.
- R3: With zero write length, zero read length and `d_cmd`=0, the sequence is start, address byte, stop. A clean quick command reports status 8'h01 (bit 0 = success).
- R4: When a write phase and a nonzero read length both exist, the write phase is followed by a repeated start (code 2), the read address byte, and then the reads. Operation codes: 1 start, 2 repeated start, 3 write, 4 read, 5 stop.
- R5: In a read phase, every byte except the last is acknowledged (`op_ack`=1) and the last is NAKed (`op_ack`=0). Read data bytes go into the buffer from index 0 upward in arrival order, so a word arrives low byte first at index 0.
- R6: In block mode (`d_blk`=1 with a read phase), the first read byte is a count. It is acknowledged, and it is neither stored nor counted. Exactly that many data bytes follow.
- R7: A block count above 32 or equal to 0 causes one more read with `op_ack`=0, then stop, with no data stored. A count above 32 sets status bit 6 (large packet) and clears success.
- R8: A NAK on any written byte (address or data) is followed immediately by stop. It sets status bit 1, leaves bit 0 clear, and the NAKed byte is not counted.
- R9: Engine error flags `op_err[0..3]` (data-low timeout, clock-low timeout, collision, CRC) set status bits 2 to 5 respectively, and the transaction proceeds to stop.
- R10: `tx_count` and `rx_count` count only data bytes whose operation completed cleanly. Status bit 0 is set only when no other status bit is set.
- R11: `done` is a one-cycle pulse in the cycle after the stop completes. A `start` while `busy` is 1 is ignored.
- R12: After reset, `busy`, `done`, `op_req`, `status`, `tx_count` and `rx_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transaction from the descriptor fields (sampled only in IDLE) |
| d_addr | input | 7 | Target address |
| d_rnw | input | 1 | Direction bit, used only for a quick command |
| d_wlen | input | 8 | Write byte count, or the command byte when `d_cmd` is 1 |
| d_rlen | input | 8 | Read byte count; in block mode, nonzero enables the block read |
| d_cmd | input | 1 | `d_wlen` is a single command byte |
| d_blk | input | 1 | Read phase begins with a byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 7 | Bit 0 success, 1 NAK, 2 to 5 engine errors, 6 large packet |
| tx_count | output | 8 | Data bytes written cleanly |
| rx_count | output | 8 | Data bytes read cleanly |
| buf_raddr | output | 6 | Buffer read index for the next write byte |
| buf_rdata | input | 8 | Buffer byte at `buf_raddr` |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| buf_waddr | output | 6 | Buffer write index |
| buf_wdata | output | 8 | Received byte |
| op_req | output | 1 | Operation request, held until `op_done` |
| op_code | output | 3 | Operation code (see R4) |
| op_wbyte | output | 8 | Byte to write |
| op_ack | output | 1 | Acknowledge to give on a read |
| op_done | input | 1 | Engine completion pulse |
| op_rbyte | input | 8 | Byte read by the engine |
| op_nak | input | 1 | Target NAKed the written byte |
| op_err | input | 4 | Engine error flags |

## Verification
Every descriptor form is run against a behavioural engine and target model: quick write, quick read, send byte, receive byte, word write, word read, good block read and oversized block read. These runs separate the address-bit choice, command-versus-buffer sourcing, repeated-start insertion and the block-count path. Faults are then injected at chosen operation positions: a NAK on the address, a NAK on the second data byte, a collision on a write and a CRC error on a read. These cases separate early termination from counting and check that success is withheld. A second `start` issued mid-transaction must leave the operation stream unchanged and produce only one `done`.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ERR_W  = 4;
    localparam int unsigned STAT_W = ERR_W + 3;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4,
        OP_STOP   = 3'd5
    } op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic [BYTE_W-1:0] wlen;
        logic [BYTE_W-1:0] rlen;
        logic              cmd;
        logic              blk;
    } desc_t;
endpackage

// File: rtl/smb_form_decode.sv
module smb_form_decode
    import smbseq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              cmd,
    input  logic [BYTE_W-1:0] wlen,
    input  logic [BYTE_W-1:0] rlen,
    output logic              has_wr,
    output logic              has_rd,
    output logic [BYTE_W-1:0] addr_first,
    output logic [BYTE_W-1:0] addr_read
);
    logic first_rw;

    always_comb begin
        has_wr     = cmd || (wlen != '0);
        has_rd     = (rlen != '0);
        first_rw   = has_wr ? 1'b0 : (has_rd ? 1'b1 : rnw);
        addr_first = {addr, first_rw};
        addr_read  = {addr, 1'b1};
    end
endmodule

// File: rtl/smb_xfer_count.sv
module smb_xfer_count
    import smbseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tx_inc,
    input  logic              rx_inc,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_val,
    input  logic              dec,
    output logic [BYTE_W-1:0] tx_cnt,
    output logic [BYTE_W-1:0] rx_cnt,
    output logic [BYTE_W-1:0] left
);
    localparam logic [BYTE_W-1:0] BONE = BYTE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else if (clr) begin
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else begin
            if (tx_inc) tx_cnt <= tx_cnt + BONE;
            if (rx_inc) rx_cnt <= rx_cnt + BONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   left <= '0;
        else if (ld)  left <= ld_val;
        else if (dec) left <= left - BONE;
    end
endmodule

// File: rtl/smb_status_acc.sv
module smb_status_acc
    import smbseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              nak_ev,
    input  logic [ERR_W-1:0]  err_bits,
    input  logic              lpr_ev,
    input  logic              fin_ev,
    output logic [STAT_W-1:0] status
);
    logic             ok_q, nak_q, lpr_q;
    logic [ERR_W-1:0] err_q;
    logic             any_bad;

    for (genvar g = 0; g < ERR_W; g++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           err_q[g] <= 1'b0;
            else if (clr)         err_q[g] <= 1'b0;
            else if (err_bits[g]) err_q[g] <= 1'b1;
        end
    end

    assign any_bad = nak_q || lpr_q || (err_q != '0) || nak_ev || lpr_ev || (err_bits != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            nak_q <= 1'b0;
            lpr_q <= 1'b0;
        end else if (clr) begin
            ok_q  <= 1'b0;
            nak_q <= 1'b0;
            lpr_q <= 1'b0;
        end else begin
            if (nak_ev) nak_q <= 1'b1;
            if (lpr_ev) lpr_q <= 1'b1;
            if (fin_ev) ok_q  <= !any_bad;
        end
    end

    assign status = {lpr_q, err_q, nak_q, ok_q};
endmodule

// File: rtl/smbus_desc_seq.sv
module smbus_desc_seq
    import smbseq_pkg::*;
#(
    parameter int unsigned BLK_MAX = 32,
    parameter int unsigned IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_rnw,
    input  logic [BYTE_W-1:0] d_wlen,
    input  logic [BYTE_W-1:0] d_rlen,
    input  logic              d_cmd,
    input  logic              d_blk,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] status,
    output logic [BYTE_W-1:0] tx_count,
    output logic [BYTE_W-1:0] rx_count,
    output logic [IDX_W-1:0]  buf_raddr,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_waddr,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              op_req,
    output logic [2:0]        op_code,
    output logic [BYTE_W-1:0] op_wbyte,
    output logic              op_ack,
    input  logic              op_done,
    input  logic [BYTE_W-1:0] op_rbyte,
    input  logic              op_nak,
    input  logic [ERR_W-1:0]  op_err
);
    localparam logic [BYTE_W-1:0] BONE    = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] BLK_LIM = BYTE_W'(BLK_MAX);

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR, S_WRITE, S_RSTART, S_RADDR,
        S_RCOUNT, S_READ, S_DRAIN, S_STOP, S_FINISH
    } state_e;

    state_e            state_q, state_d, adv;
    desc_t             desc_q;
    op_e               op_sel;
    logic              has_wr, has_rd;
    logic [BYTE_W-1:0] addr_first, addr_read, left;
    logic              in_op, nak_now, err_now, fail_now, ok_now;
    logic              wr_last, blk_bad, cnt_clr, tx_inc, ld, lpr_ev, fin_ev;
    logic [BYTE_W-1:0] ld_val;
    logic [ERR_W-1:0]  err_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) desc_q <= '0;
        else if (state_q == S_IDLE && start)
            desc_q <= '{addr: d_addr, rnw: d_rnw, wlen: d_wlen,
                        rlen: d_rlen, cmd: d_cmd, blk: d_blk};
    end

    smb_form_decode u_decode (
        .addr(desc_q.addr), .rnw(desc_q.rnw), .cmd(desc_q.cmd),
        .wlen(desc_q.wlen), .rlen(desc_q.rlen),
        .has_wr(has_wr), .has_rd(has_rd),
        .addr_first(addr_first), .addr_read(addr_read)
    );

    // operation outcome
    always_comb begin
        in_op    = !(state_q inside {S_IDLE, S_FINISH});
        nak_now  = op_done && op_nak && (state_q inside {S_ADDR, S_WRITE, S_RADDR});
        err_now  = op_done && in_op && (op_err != '0);
        fail_now = nak_now || err_now;
        ok_now   = op_done && in_op && !fail_now;
        wr_last  = desc_q.cmd || ((tx_count + BONE) == desc_q.wlen);
        blk_bad  = (op_rbyte == '0) || (op_rbyte > BLK_LIM);
    end

    // successor on clean completion
    always_comb begin
        adv = S_STOP;
        unique case (state_q)
            S_START:  adv = S_ADDR;
            S_ADDR:   adv = has_wr ? S_WRITE : (has_rd ? (desc_q.blk ? S_RCOUNT : S_READ) : S_STOP);
            S_WRITE:  adv = wr_last ? (has_rd ? S_RSTART : S_STOP) : S_WRITE;
            S_RSTART: adv = S_RADDR;
            S_RADDR:  adv = desc_q.blk ? S_RCOUNT : S_READ;
            S_RCOUNT: adv = blk_bad ? S_DRAIN : S_READ;
            S_READ:   adv = (left == BONE) ? S_STOP : S_READ;
            default:  adv = S_STOP;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_START;
            S_STOP:   if (op_done) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default: begin
                if (fail_now)    state_d = S_STOP;
                else if (ok_now) state_d = adv;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs toward the engine
    always_comb begin
        op_sel   = OP_NONE;
        op_wbyte = '0;
        op_ack   = 1'b0;
        unique case (state_q)
            S_START:  op_sel = OP_START;
            S_ADDR:   begin op_sel = OP_WRITE; op_wbyte = addr_first; end
            S_WRITE:  begin op_sel = OP_WRITE; op_wbyte = desc_q.cmd ? desc_q.wlen : buf_rdata; end
            S_RSTART: op_sel = OP_RSTART;
            S_RADDR:  begin op_sel = OP_WRITE; op_wbyte = addr_read; end
            S_RCOUNT: begin op_sel = OP_READ; op_ack = 1'b1; end
            S_READ:   begin op_sel = OP_READ; op_ack = (left != BONE); end
            S_DRAIN:  op_sel = OP_READ;
            S_STOP:   op_sel = OP_STOP;
            default:  op_sel = OP_NONE;
        endcase
    end

    assign op_req  = in_op;
    assign op_code = op_sel;
    assign busy    = (state_q != S_IDLE);
    assign done    = (state_q == S_FINISH);

    // counters and buffer
    assign cnt_clr   = (state_q == S_IDLE) && start;
    assign tx_inc    = (state_q == S_WRITE) && ok_now;
    assign buf_we    = (state_q == S_READ) && ok_now;
    assign ld        = cnt_clr || ((state_q == S_RCOUNT) && ok_now);
    assign ld_val    = cnt_clr ? d_rlen : op_rbyte;
    assign buf_raddr = tx_count[IDX_W-1:0];
    assign buf_waddr = rx_count[IDX_W-1:0];
    assign buf_wdata = op_rbyte;

    smb_xfer_count u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tx_inc(tx_inc), .rx_inc(buf_we),
        .ld(ld), .ld_val(ld_val), .dec(buf_we),
        .tx_cnt(tx_count), .rx_cnt(rx_count), .left(left)
    );

    assign err_bits = err_now ? op_err : '0;
    assign lpr_ev   = (state_q == S_RCOUNT) && ok_now && (op_rbyte > BLK_LIM);
    assign fin_ev   = (state_q == S_STOP) && op_done;

    smb_status_acc u_status (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .nak_ev(nak_now),
        .err_bits(err_bits), .lpr_ev(lpr_ev), .fin_ev(fin_ev), .status(status)
    );
endmodule

// File: rtl/smbus_desc_seq_chk.sv
module smbus_desc_seq_chk
    import smbseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [STAT_W-1:0] status,
    input logic [BYTE_W-1:0] rx_count,
    input logic              op_req,
    input logic [2:0]        op_code,
    input logic              op_done,
    input logic              op_nak,
    input logic [ERR_W-1:0]  op_err,
    input logic              buf_we
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_SUCCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(status[0] && (status[STAT_W-1:1] != '0))); // R10

    AST_NAK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_done && op_nak && op_code == OP_WRITE) |=> (op_req && op_code == OP_STOP)); // R8

    AST_ERR_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_done && (op_err != '0) && op_code != OP_STOP) |=> (op_req && op_code == OP_STOP)); // R9

    AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (rx_count == $past(rx_count) || rx_count == $past(rx_count) + 8'd1)); // R10

    AST_BUF_WE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (op_done && op_req && op_code == OP_READ)); // R5
endmodule

bind smbus_desc_seq smbus_desc_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
    .rx_count(rx_count), .op_req(op_req), .op_code(op_code), .op_done(op_done),
    .op_nak(op_nak), .op_err(op_err), .buf_we(buf_we)
);

// File: tb/smbus_desc_seq_bench.sv
module smbus_desc_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] d_addr = '0;
    logic       d_rnw = 1'b0;
    logic [7:0] d_wlen = '0, d_rlen = '0;
    logic       d_cmd = 1'b0, d_blk = 1'b0;
    logic       busy, done, buf_we, op_req, op_ack;
    logic [6:0] status;
    logic [7:0] tx_count, rx_count, buf_rdata, buf_wdata, op_wbyte;
    logic [5:0] buf_raddr, buf_waddr;
    logic [2:0] op_code;
    logic       op_done, op_nak;
    logic [7:0] op_rbyte;
    logic [3:0] op_err;

    logic [7:0] mem [0:63];
    logic       tb_we = 1'b0;
    logic [5:0] tb_wa = '0;
    logic [7:0] tb_wd = '0;
    logic [7:0] rsp [0:7];
    int         nak_idx = -1, err_idx = -1;
    logic [3:0] err_val = '0;
    int         n_chk = 0, n_fail = 0, done_cnt = 0;
    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_desc_seq u_smbus_desc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .d_addr(d_addr), .d_rnw(d_rnw),
        .d_wlen(d_wlen), .d_rlen(d_rlen), .d_cmd(d_cmd), .d_blk(d_blk),
        .busy(busy), .done(done), .status(status), .tx_count(tx_count), .rx_count(rx_count),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .op_req(op_req), .op_code(op_code), .op_wbyte(op_wbyte),
        .op_ack(op_ack), .op_done(op_done), .op_rbyte(op_rbyte), .op_nak(op_nak), .op_err(op_err)
    );

    assign buf_rdata = mem[buf_raddr];
    always @(posedge clk) begin
        if (buf_we)     mem[buf_waddr] <= buf_wdata;
        else if (tb_we) mem[tb_wa] <= tb_wd;
    end
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic ex(input logic [2:0] code, input logic [7:0] b, input logic ack, input string tag);
        exp_q.push_back({code, b, ack});
        tag_q.push_back(tag);
    endtask

    task automatic load(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic run(input logic [6:0] a, input logic rw, input logic [7:0] wl, input logic [7:0] rl,
                       input logic c, input logic b, input logic poke);
        @(negedge clk);
        d_addr = a; d_rnw = rw; d_wlen = wl; d_rlen = rl; d_cmd = c; d_blk = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            d_addr = 7'h7F; d_cmd = 1'b0; d_wlen = 8'h00; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic finish_txn(input string req);
        chk({req, " all expected ops issued"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete(); tag_q.delete();
        nak_idx = -1; err_idx = -1; err_val = '0;
        @(negedge clk);
    endtask

    // engine, target model and monitor side of the scoreboard
    initial begin : engine
        logic [11:0] e;
        string       t;
        int          op_idx, rsp_ptr;
        op_done = 1'b0; op_nak = 1'b0; op_rbyte = '0; op_err = '0;
        op_idx = 0; rsp_ptr = 0;
        forever begin
            @(negedge clk);
            if (op_req) begin
                if (op_code == 3'd1) begin op_idx = 0; rsp_ptr = 0; end
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected op", 32'(op_code), 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " op code"}, 32'(op_code), 32'(e[11:9]));
                    if (e[11:9] == 3'd3) chk({t, " write byte"}, 32'(op_wbyte), 32'(e[8:1]));
                    if (e[11:9] == 3'd4) chk({t, " read ack"}, 32'(op_ack), 32'(e[0]));
                end
                repeat (LAT - 1) @(negedge clk);
                op_nak   = (op_code == 3'd3) && (op_idx == nak_idx);
                op_err   = (op_idx == err_idx) ? err_val : 4'd0;
                op_rbyte = (op_code == 3'd4) ? rsp[rsp_ptr] : 8'd0;
                if (op_code == 3'd4) rsp_ptr++;
                op_idx++;
                op_done = 1'b1;
                @(negedge clk);
                op_done = 1'b0; op_nak = 1'b0; op_err = '0;
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 busy", 32'(busy), 0); chk("R12 done", 32'(done), 0);
        chk("R12 op_req", 32'(op_req), 0); chk("R12 status", 32'(status), 0);
        chk("R12 tx", 32'(tx_count), 0); chk("R12 rx", 32'(rx_count), 0);

        // quick write: rw from d_rnw
        ex(1, 0, 0, "R3"); ex(3, 8'h54, 0, "R1"); ex(5, 0, 0, "R3");
        run(7'h2A, 0, 0, 0, 0, 0, 0);
        chk("R3 quick write status", 32'(status), 32'h01);
        chk("R10 quick tx", 32'(tx_count), 0);
        finish_txn("R3");

        // quick read
        ex(1, 0, 0, "R3"); ex(3, 8'h55, 0, "R1"); ex(5, 0, 0, "R3");
        run(7'h2A, 1, 0, 0, 0, 0, 0);
        chk("R3 quick read status", 32'(status), 32'h01);
        finish_txn("R1");

        // send byte: wlen is the command byte
        ex(1, 0, 0, "R2"); ex(3, 8'h54, 0, "R1"); ex(3, 8'hA5, 0, "R2"); ex(5, 0, 0, "R2");
        run(7'h2A, 1, 8'hA5, 0, 1, 0, 0);
        chk("R2 send byte tx", 32'(tx_count), 1);
        chk("R10 send byte status", 32'(status), 32'h01);
        finish_txn("R2");

        // receive byte: read only, last byte NAKed
        rsp[0] = 8'h3C;
        ex(1, 0, 0, "R5"); ex(3, 8'h55, 0, "R1"); ex(4, 0, 0, "R5"); ex(5, 0, 0, "R5");
        run(7'h2A, 0, 0, 1, 0, 0, 0);
        chk("R5 receive rx", 32'(rx_count), 1);
        chk("R5 receive buf0", 32'(mem[0]), 32'h3C);
        finish_txn("R5");

        // word write from buffer in index order
        load(0, 8'h10); load(1, 8'h34); load(2, 8'h12);
        ex(1, 0, 0, "R2"); ex(3, 8'hA0, 0, "R1"); ex(3, 8'h10, 0, "R2");
        ex(3, 8'h34, 0, "R2"); ex(3, 8'h12, 0, "R2"); ex(5, 0, 0, "R2");
        run(7'h50, 0, 3, 0, 0, 0, 0);
        chk("R2 word write tx", 32'(tx_count), 3);
        chk("R2 word write status", 32'(status), 32'h01);
        finish_txn("R2");

        // word read: command, repeated start, ACK then NAK
        rsp[0] = 8'hCD; rsp[1] = 8'hAB;
        ex(1, 0, 0, "R4"); ex(3, 8'hA0, 0, "R1"); ex(3, 8'h07, 0, "R2"); ex(2, 0, 0, "R4");
        ex(3, 8'hA1, 0, "R1"); ex(4, 0, 1, "R5"); ex(4, 0, 0, "R5"); ex(5, 0, 0, "R4");
        run(7'h50, 0, 8'h07, 2, 1, 0, 0);
        chk("R5 word read rx", 32'(rx_count), 2);
        chk("R5 word low byte", 32'(mem[0]), 32'hCD);
        chk("R5 word high byte", 32'(mem[1]), 32'hAB);
        chk("R10 word read tx", 32'(tx_count), 1);
        finish_txn("R4");

        // block read, count 3
        rsp[0] = 8'd3; rsp[1] = 8'h11; rsp[2] = 8'h22; rsp[3] = 8'h33;
        ex(1, 0, 0, "R6"); ex(3, 8'hA0, 0, "R6"); ex(3, 8'h20, 0, "R6"); ex(2, 0, 0, "R6");
        ex(3, 8'hA1, 0, "R6"); ex(4, 0, 1, "R6"); ex(4, 0, 1, "R6"); ex(4, 0, 1, "R6");
        ex(4, 0, 0, "R6"); ex(5, 0, 0, "R6");
        run(7'h50, 0, 8'h20, 1, 1, 1, 0);
        chk("R6 block rx", 32'(rx_count), 3);
        chk("R6 block buf0", 32'(mem[0]), 32'h11);
        chk("R6 block buf2", 32'(mem[2]), 32'h33);
        chk("R6 block status", 32'(status), 32'h01);
        finish_txn("R6");

        // block read, oversize count 40
        rsp[0] = 8'd40; rsp[1] = 8'h99;
        ex(1, 0, 0, "R7"); ex(3, 8'hA0, 0, "R7"); ex(3, 8'h20, 0, "R7"); ex(2, 0, 0, "R7");
        ex(3, 8'hA1, 0, "R7"); ex(4, 0, 1, "R7"); ex(4, 0, 0, "R7"); ex(5, 0, 0, "R7");
        run(7'h50, 0, 8'h20, 1, 1, 1, 0);
        chk("R7 large packet status", 32'(status), 32'h40);
        chk("R7 large packet rx", 32'(rx_count), 0);
        chk("R7 buffer untouched", 32'(mem[0]), 32'h11);
        finish_txn("R7");

        // NAK on address
        load(0, 8'h10); load(1, 8'h34); load(2, 8'h12);
        nak_idx = 1;
        ex(1, 0, 0, "R8"); ex(3, 8'h54, 0, "R8"); ex(5, 0, 0, "R8");
        run(7'h2A, 0, 3, 0, 0, 0, 0);
        chk("R8 address NAK status", 32'(status), 32'h02);
        chk("R8 address NAK tx", 32'(tx_count), 0);
        finish_txn("R8");

        // NAK on second data byte
        nak_idx = 3;
        ex(1, 0, 0, "R8"); ex(3, 8'h54, 0, "R8"); ex(3, 8'h10, 0, "R8");
        ex(3, 8'h34, 0, "R8"); ex(5, 0, 0, "R8");
        run(7'h2A, 0, 3, 0, 0, 0, 0);
        chk("R8 data NAK status", 32'(status), 32'h02);
        chk("R10 data NAK tx", 32'(tx_count), 1);
        finish_txn("R8");

        // collision on first data write
        err_idx = 2; err_val = 4'b0100;
        ex(1, 0, 0, "R9"); ex(3, 8'h54, 0, "R9"); ex(3, 8'h10, 0, "R9"); ex(5, 0, 0, "R9");
        run(7'h2A, 0, 3, 0, 0, 0, 0);
        chk("R9 collision status", 32'(status), 32'h10);
        chk("R10 collision tx", 32'(tx_count), 0);
        finish_txn("R9");

        // CRC error on a read byte
        rsp[0] = 8'h77;
        err_idx = 2; err_val = 4'b1000;
        ex(1, 0, 0, "R9"); ex(3, 8'h55, 0, "R9"); ex(4, 0, 0, "R9"); ex(5, 0, 0, "R9");
        run(7'h2A, 0, 0, 1, 0, 0, 0);
        chk("R9 crc status", 32'(status), 32'h20);
        chk("R10 crc rx", 32'(rx_count), 0);
        finish_txn("R9");

        // start while busy is ignored
        d0 = done_cnt;
        ex(1, 0, 0, "R11"); ex(3, 8'h54, 0, "R11"); ex(3, 8'hA5, 0, "R11"); ex(5, 0, 0, "R11");
        run(7'h2A, 0, 8'hA5, 0, 1, 0, 1);
        chk("R11 status", 32'(status), 32'h01);
        finish_txn("R11");
        repeat (4) @(negedge clk);
        chk("R11 one done pulse", 32'(done_cnt - d0), 1);
        chk("R11 idle after", 32'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule